// File: doc/BRIEF.md
# Serial Memory Sequential Read Controller

This block is the device-side logic of a byte-wide serial memory, limited to the sequential array read command. A host lowers an active-low chip select and clocks in one instruction byte and a 16-bit address on the serial data input. The block then returns stored bytes on a serial data output that has a separate output-enable, so a pad driver can place it in high impedance. While chip select stays low the address advances after every byte, and the stream continues past the top of the array back to address zero. One command can therefore dump the whole array.

Everything runs on one system clock `clk`. The serial pins `cs_n`, `sclk` and `mosi` are taken as synchronous to `clk`, and `sclk` must hold each level for at least two `clk` cycles. The block detects serial clock edges internally. Input bits are taken on serial clock rising edges and output bits change after falling edges, as in SPI mode 0. A write-busy input from the rest of the memory refuses the command.

The array contents enter through a load stream port with a valid/ready handshake. `load_ready` is high only while chip select is high, so a read never sees the array change. A producer that finds `load_ready` low must hold `load_valid`, `load_addr` and `load_data` steady. The byte is written on the first clock edge where both valid and ready are high.

Top module: `spi_rom_reader`

## Requirements
- R1: After `cs_n` falls, `sdo_en` stays low during the 24 header bits: 8 instruction bits followed by 16 address bits.
- R2: Header bits are taken from `mosi` on `sclk` rising edges, most significant bit first. The instruction value 8'h03 starts a read. Any other value keeps `sdo_en` low until `cs_n` rises.
- R3: Only the low log2(DEPTH) bits of the 16-bit address select the start byte. Higher address bits have no effect on the returned data.
- R4: The first data bit appears after the `sclk` falling edge that follows the 24th rising edge. Each byte is sent most significant bit first. `sdo` changes only after `sclk` falling edges, and `sdo_en` stays high for every data bit.
- R5: While `cs_n` stays low, each completed byte is followed by the byte at the next address, with no new command.
- R6: After the byte at address DEPTH-1, the stream continues with address 0.
- R7: Raising `cs_n` at any point, including mid-byte, drops `sdo_en` and clears all bit counters. The next frame is decoded from its first bit.
- R8: `wip` is sampled on the 8th header rising edge. If it is high, the command is refused and `sdo_en` stays low for the whole frame.
- R9: `load_ready` equals `cs_n`. A byte offered on the load port is written to `load_addr` only on a clock edge where both `load_valid` and `load_ready` are high. An offer held through a frame is written after `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data in |
| wip | input | 1 | Internal write busy; refuses the command |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for `sdo`; low means high impedance |
| load_valid | input | 1 | Load byte offered |
| load_ready | output | 1 | Load byte can be taken |
| load_addr | input | log2(DEPTH) | Load byte address |
| load_data | input | 8 | Load byte value |

## Verification
The read stream is driven with directed starts in mid-array, at DEPTH-2 so the stream crosses the wrap, and with upper address bits set. Random start addresses and random byte counts are added on top. Together these separate a correct increment from a stuck or page-bounded counter, and masking of the upper address bits from using them. Refused frames, a wrong instruction value or a busy write, are told apart from accepted ones by watching the output enable. A frame cut mid-byte, followed by a fresh frame, shows whether the counters restart. A load offered during a frame shows that back-pressure holds the byte until chip select rises.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WAIT,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_SEQ_READ = 8'h03;
  localparam int         HDR_OP_BITS = 8;
  localparam int         HDR_AD_BITS = 16;
endpackage

// File: rtl/spi_rd_edge.sv
module spi_rd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/spi_rd_hdr.sv
module spi_rd_hdr
  import spi_rd_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          mosi,
  input  logic          wip,
  output phase_t        phase,
  output logic          hdr_done,
  output logic [AW-1:0] start_addr
);
  localparam int SRW = (AW - 1 > 7) ? AW - 1 : 7;

  logic [SRW-1:0] sr;
  logic [4:0]     cnt;
  logic [7:0]     op_now;

  assign op_now     = {sr[6:0], mosi};
  assign start_addr = {sr[AW-2:0], mosi};
  assign hdr_done   = !cs_n && (phase == PH_ADDR) && rise &&
                      (cnt == 5'(HDR_AD_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
      sr    <= '0;
    end else begin
      unique case (phase)
        PH_CMD: if (rise) begin
          sr  <= {sr[SRW-2:0], mosi};
          cnt <= cnt + 5'd1;
          if (cnt == 5'(HDR_OP_BITS - 1)) begin
            cnt   <= '0;
            phase <= (op_now == OP_SEQ_READ && !wip) ? PH_ADDR : PH_SKIP;
          end
        end
        PH_ADDR: if (rise) begin
          sr  <= {sr[SRW-2:0], mosi};
          cnt <= cnt + 5'd1;
          if (cnt == 5'(HDR_AD_BITS - 1)) phase <= PH_WAIT;
        end
        PH_WAIT: if (fall) phase <= PH_DATA;
        default: phase <= phase;
      endcase
    end
  end
endmodule

// File: rtl/spi_rd_array.sv
module spi_rd_array #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_rom_reader.sv
module spi_rom_reader
  import spi_rd_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          wip,
  output logic          sdo,
  output logic          sdo_en,
  input  logic          load_valid,
  output logic          load_ready,
  input  logic [AW-1:0] load_addr,
  input  logic [7:0]    load_data
);
  logic          sclk_rise, sclk_fall;
  phase_t        phase;
  logic          hdr_done;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] cur_addr, next_addr, rd_addr;
  logic [7:0]    rd_data, out_sr;
  logic [2:0]    bit_pos;

  spi_rd_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  spi_rd_hdr #(.AW(AW)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .mosi      (mosi),
    .wip       (wip),
    .phase     (phase),
    .hdr_done  (hdr_done),
    .start_addr(start_addr)
  );

  assign load_ready = cs_n;
  assign next_addr  = cur_addr + AW'(1);
  assign rd_addr    = (phase == PH_DATA) ? next_addr : cur_addr;

  spi_rd_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk    (clk),
    .wr_en  (load_valid & load_ready),
    .wr_addr(load_addr),
    .wr_data(load_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      out_sr   <= '0;
      bit_pos  <= '0;
    end else if (cs_n) begin
      bit_pos <= '0;
    end else begin
      if (hdr_done) cur_addr <= start_addr;
      if (phase == PH_WAIT && sclk_fall) begin
        out_sr  <= rd_data;
        bit_pos <= '0;
      end else if (phase == PH_DATA && sclk_fall) begin
        if (bit_pos == 3'd7) begin
          cur_addr <= next_addr;
          out_sr   <= rd_data;
          bit_pos  <= '0;
        end else begin
          out_sr  <= {out_sr[6:0], 1'b0};
          bit_pos <= bit_pos + 3'd1;
        end
      end
    end
  end

  assign sdo    = out_sr[7];
  assign sdo_en = !cs_n && (phase == PH_DATA);
endmodule

// File: rtl/spi_rom_reader_chk.sv
module spi_rom_reader_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wip,
  input logic          sdo,
  input logic          sdo_en,
  input logic          sclk_rise,
  input logic          sclk_fall,
  input logic [AW-1:0] cur_addr,
  input logic [2:0]    bit_pos
);
  logic [5:0] rise_cnt;
  logic       op_wip;

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      rise_cnt <= '0;
      op_wip   <= 1'b0;
    end else if (sclk_rise) begin
      if (rise_cnt != 6'd63) rise_cnt <= rise_cnt + 6'd1;
      if (rise_cnt == 6'd7)  op_wip   <= wip;
    end
  end

  p_hiz_header_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rise_cnt < 6'd24) |-> !sdo_en);

  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en) && !$past(sclk_fall)) |-> $stable(sdo));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && sclk_fall && bit_pos == 3'd7) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sdo_en);

  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> !op_wip);
endmodule

bind spi_rom_reader spi_rom_reader_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .wip      (wip),
  .sdo      (sdo),
  .sdo_en   (sdo_en),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .cur_addr (cur_addr),
  .bit_pos  (bit_pos)
);

// File: tb/spi_rom_reader_tb.sv
module spi_rom_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2048;
  localparam int AW         = $clog2(DEPTH);
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi, wip;
  logic sdo, sdo_en, load_valid, load_ready;
  logic [AW-1:0] load_addr;
  logic [7:0]    load_data;

  logic [7:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rom_reader #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wip(wip), .sdo(sdo), .sdo_en(sdo_en), .load_valid(load_valid),
    .load_ready(load_ready), .load_addr(load_addr), .load_data(load_data)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [15:0] a, input int k);
    return model[(int'(a) + k) % DEPTH];
  endfunction

  task automatic spi_frame(input logic [7:0] op, input logic [15:0] a,
                           input int nbits, input logic w, input string req);
    logic [23:0] hdr;
    logic [7:0]  got;
    int hdr_bad, en_seen;
    bit take;
    hdr = {op, a}; hdr_bad = 0; en_seen = 0; got = '0;
    take = (op == 8'h03) && !w;
    wip = w; cs_n = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      sclk = 1'b0; mosi = hdr[i];
      wait_clks(HALF);
      if (sdo_en) hdr_bad++;
      sclk = 1'b1;
      wait_clks(HALF);
    end
    check(hdr_bad == 0, "R1 header hi-z", hdr_bad, 0);
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b0;
      wait_clks(HALF);
      if (sdo_en) en_seen++;
      got = {got[6:0], sdo};
      if (take && (b % 8 == 7))
        check(got == exp_byte(a, b / 8), req, int'(got), int'(exp_byte(a, b / 8)));
      sclk = 1'b1;
      wait_clks(HALF);
    end
    sclk = 1'b0;
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(2);
    check(!sdo_en, "R7 enable drops", int'(sdo_en), 0);
    if (take) check(en_seen == nbits, "R4 enable per data bit", en_seen, nbits);
    else      check(en_seen == 0, req, en_seen, 0);
    wip = 1'b0;
    wait_clks(HALF);
  endtask

  initial begin
    int unsigned sd;
    logic [7:0] v;
    sd = $urandom(32'd7321);
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; wip = 1'b0;
    load_valid = 1'b0; load_addr = '0; load_data = '0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    check(!sdo_en, "R7 reset enable", int'(sdo_en), 0);
    check(load_ready, "R9 reset ready", int'(load_ready), 1);

    // fill the array through the load stream
    for (int i = 0; i < DEPTH; i++) begin
      v = 8'($urandom);
      load_valid = 1'b1; load_addr = AW'(i); load_data = v;
      model[i] = v;
      wait_clks(1);
    end
    load_valid = 1'b0;
    wait_clks(2);

    spi_frame(8'h03, 16'h0010, 24, 1'b0, "R5 sequential bytes");
    spi_frame(8'h03, 16'hF805, 16, 1'b0, "R3 upper bits ignored");
    spi_frame(8'h03, 16'(DEPTH - 2), 32, 1'b0, "R6 wrap to zero");
    spi_frame(8'h0B, 16'h0040, 16, 1'b0, "R2 other opcode refused");
    spi_frame(8'h02, 16'h0040, 8, 1'b0, "R2 other opcode refused");
    spi_frame(8'h03, 16'h0040, 16, 1'b1, "R8 busy refused");
    spi_frame(8'h03, 16'h0200, 13, 1'b0, "R7 mid-byte stop");
    spi_frame(8'h03, 16'h0100, 8, 1'b0, "R7 fresh frame after stop");

    // back-pressure on the load port during a frame
    v = ~model[16'h0123];
    cs_n = 1'b0;
    load_valid = 1'b1; load_addr = AW'(16'h0123); load_data = v;
    wait_clks(3);
    check(!load_ready, "R9 ready low in frame", int'(load_ready), 0);
    cs_n = 1'b1;
    wait_clks(1);
    load_valid = 1'b0;
    model[16'h0123] = v;
    wait_clks(2);
    spi_frame(8'h03, 16'h0123, 8, 1'b0, "R9 held offer written");

    for (int r = 0; r < 20; r++) begin
      spi_frame(8'h03, 16'($urandom), 8 * (1 + int'($urandom % 4)), 1'b0,
                "R5 random stream");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule